// File: doc/BRIEF.md
# Power-Up and Oscillator Start Sequencer

This block keeps the core in reset after a power-on event, a brown-out event or a wake-up from sleep. It releases the reset only after the delay phases that apply to that event have run. There are two possible phases, and they always run in the same order. The first is a power-up wait, measured in ticks of a slow timebase. The second is an oscillator stabilisation count, measured in core clock cycles. Three things decide which phases run: the kind of event, whether the power-up timer is enabled, and whether the oscillator is a crystal type or an RC network.

Each event arrives as a strobe sampled on a rising clock edge. Power-on and brown-out strobes are always accepted, and an accepted one restarts the sequence from the beginning. A wake strobe is accepted only while the block is idle. Both phase lengths are parameters, so simulation can use short values. The block drives a reset-hold level. It also gives a one-cycle done pulse in the last cycle that the hold is asserted.

Top module: `pwrup_sequencer`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `hold_rst` and `done` are 0; a strobe sampled together with `rst` is ignored, and `rst` aborts a running sequence.
- R2: Crystal mode (`osc_is_rc`=0) with the timer enabled (`pwrt_en`=1): after a power-on or brown-out strobe, the hold lasts PWR_TICKS timebase ticks, then OSC_CYCLES clocks, then one release cycle.
- R3: Crystal mode with the timer disabled: after a power-on or brown-out strobe, the hold lasts OSC_CYCLES clocks plus one release cycle.
- R4: RC mode (`osc_is_rc`=1) with the timer enabled: after a power-on or brown-out strobe, the hold lasts PWR_TICKS ticks plus one release cycle, with no clock count.
- R5: RC mode with the timer disabled: a power-on strobe gives a hold of a single release cycle, while a brown-out strobe still runs the PWR_TICKS tick wait.
- R6: A wake strobe never runs the tick wait. It holds for OSC_CYCLES clocks plus one release cycle in crystal mode, and for one release cycle in RC mode.
- R7: A power-on or brown-out strobe that arrives while the hold is asserted restarts the sequence from its first phase. A wake strobe that arrives while the hold is asserted has no effect on the hold length.
- R8: `done` is high for exactly one cycle per sequence. That cycle is the last one with `hold_rst` high, and `hold_rst` is low in the next cycle unless a new strobe arrives.
- R9: When strobes arrive together, power-on has priority over brown-out, and brown-out has priority over wake.
- R10: The tick wait counts only `tick` pulses sampled during that phase. Ticks that arrive during the clock count have no effect on its length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock; also the clock the stabilisation count measures |
| rst | input | 1 | Synchronous active-high reset |
| por_trig | input | 1 | Power-on event strobe |
| bor_trig | input | 1 | Brown-out event strobe |
| wake_trig | input | 1 | Wake-from-sleep event strobe |
| pwrt_en | input | 1 | 1 enables the power-up tick wait |
| osc_is_rc | input | 1 | 1 = RC oscillator, 0 = crystal-type oscillator |
| tick | input | 1 | One-cycle pulse from the slow timebase |
| hold_rst | output | 1 | High while the core must stay in reset |
| done | output | 1 | One-cycle pulse in the final hold cycle |

## Verification
A wrong phase plan or a miscounting counter shows up at the ports as a hold of the wrong length. The error is visible in the first cycle that `hold_rst` falls early or stays high too long, and it is never more than PWR_TICKS·P + OSC_CYCLES + 1 cycles after the strobe. The bench sweeps every combination of event kind, oscillator mode, timer enable and tick spacing, and compares each hold length with the arithmetic sum of its phases. A bad restart, a bad priority or a bad stored plan shows up on the first sequence that exercises it, either as a changed length or as a missing or doubled `done` pulse.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE     = 2'd0,
        SQ_PWR_WAIT = 2'd1,
        SQ_OSC_WAIT = 2'd2,
        SQ_RELEASE  = 2'd3
    } sq_state_t;

    typedef enum logic [1:0] {
        TRG_NONE = 2'd0,
        TRG_POR  = 2'd1,
        TRG_BOR  = 2'd2,
        TRG_WAKE = 2'd3
    } trg_kind_t;

    typedef struct packed {
        logic run_pwr;
        logic run_osc;
    } phase_plan_t;

    // Fixed priority: power-on, then brown-out, then wake (wake only when idle).
    function automatic trg_kind_t pick_trigger(input logic por, input logic bor,
                                               input logic wake, input logic busy);
        if (por)                return TRG_POR;
        else if (bor)           return TRG_BOR;
        else if (wake && !busy) return TRG_WAKE;
        else                    return TRG_NONE;
    endfunction

    function automatic phase_plan_t plan_for(input trg_kind_t kind, input logic pwrt_en,
                                             input logic rc_mode);
        phase_plan_t p;
        p.run_osc = !rc_mode;
        unique case (kind)
            TRG_POR:  p.run_pwr = pwrt_en;
            TRG_BOR:  p.run_pwr = pwrt_en | rc_mode;
            default:  p.run_pwr = 1'b0;
        endcase
        if (kind == TRG_NONE) p.run_osc = 1'b0;
        return p;
    endfunction

endpackage

// File: rtl/trigger_decode.sv
module trigger_decode
    import pwrseq_pkg::*;
(
    input  logic        por,
    input  logic        bor,
    input  logic        wake,
    input  logic        busy,
    input  logic        pwrt_en,
    input  logic        rc_mode,
    output logic        start,
    output phase_plan_t plan
);
    trg_kind_t kind;

    always_comb begin
        kind  = pick_trigger(por, bor, wake, busy);
        start = (kind != TRG_NONE);
        plan  = plan_for(kind, pwrt_en, rc_mode);
    end

endmodule

// File: rtl/phase_counter.sv
module phase_counter #(
    parameter int LIMIT = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic step,
    output logic last
);
    localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [W-1:0] TOP = W'(LIMIT - 1);

    logic [W-1:0] cnt;

    assign last = step && (cnt == TOP);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= (cnt == TOP) ? '0 : cnt + 1'b1;
        end
    end

    // The count never leaves its range (R2, R3).
    p_count_in_range_r2: assert property (@(posedge clk) disable iff (rst)
        cnt <= TOP);

endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
    import pwrseq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  phase_plan_t plan,
    input  logic        pwr_last,
    input  logic        osc_last,
    output sq_state_t   state,
    output logic        hold_rst,
    output logic        done
);
    sq_state_t state_nx;
    logic      osc_pend;
    logic      osc_pend_nx;

    always_comb begin
        state_nx    = state;
        osc_pend_nx = osc_pend;
        if (start) begin
            osc_pend_nx = plan.run_osc;
            if (plan.run_pwr)      state_nx = SQ_PWR_WAIT;
            else if (plan.run_osc) state_nx = SQ_OSC_WAIT;
            else                   state_nx = SQ_RELEASE;
        end else begin
            unique case (state)
                SQ_PWR_WAIT: if (pwr_last) state_nx = osc_pend ? SQ_OSC_WAIT : SQ_RELEASE;
                SQ_OSC_WAIT: if (osc_last) state_nx = SQ_RELEASE;
                SQ_RELEASE:  state_nx = SQ_IDLE;
                default:     state_nx = SQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SQ_IDLE;
            osc_pend <= 1'b0;
        end else begin
            state    <= state_nx;
            osc_pend <= osc_pend_nx;
        end
    end

    assign hold_rst = (state != SQ_IDLE);
    assign done     = (state == SQ_RELEASE);

    // The done pulse lasts one cycle unless a new strobe restarts the sequence (R8).
    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> !done);
    // The hold drops in the cycle after release (R8).
    p_hold_drops_r8: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> !hold_rst);
    // The clock count never goes back to the tick wait without a new strobe (R2).
    p_osc_after_pwr_r2: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_OSC_WAIT && !start) |=> state != SQ_PWR_WAIT);

endmodule

// File: rtl/pwrup_sequencer.sv
module pwrup_sequencer
    import pwrseq_pkg::*;
#(
    parameter int PWR_TICKS  = 72,
    parameter int OSC_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic por_trig,
    input  logic bor_trig,
    input  logic wake_trig,
    input  logic pwrt_en,
    input  logic osc_is_rc,
    input  logic tick,
    output logic hold_rst,
    output logic done
);
    logic        start;
    phase_plan_t plan;
    sq_state_t   state;
    logic        pwr_step;
    logic        osc_step;
    logic        pwr_last;
    logic        osc_last;

    trigger_decode u_decode (
        .por     (por_trig),
        .bor     (bor_trig),
        .wake    (wake_trig),
        .busy    (hold_rst),
        .pwrt_en (pwrt_en),
        .rc_mode (osc_is_rc),
        .start   (start),
        .plan    (plan)
    );

    assign pwr_step = (state == SQ_PWR_WAIT) && tick && !start;
    assign osc_step = (state == SQ_OSC_WAIT) && !start;

    phase_counter #(.LIMIT(PWR_TICKS)) u_pwr_cnt (
        .clk  (clk),
        .rst  (rst),
        .clr  (start),
        .step (pwr_step),
        .last (pwr_last)
    );

    phase_counter #(.LIMIT(OSC_CYCLES)) u_osc_cnt (
        .clk  (clk),
        .rst  (rst),
        .clr  (start),
        .step (osc_step),
        .last (osc_last)
    );

    seq_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .plan     (plan),
        .pwr_last (pwr_last),
        .osc_last (osc_last),
        .state    (state),
        .hold_rst (hold_rst),
        .done     (done)
    );

    // Without a tick the tick wait does not advance (R10).
    p_tick_gates_wait_r10: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_PWR_WAIT && !tick && !por_trig && !bor_trig) |=> state == SQ_PWR_WAIT);
    // A wake strobe during the clock count leaves it running (R7).
    p_wake_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_OSC_WAIT && wake_trig && !por_trig && !bor_trig && !osc_last)
        |=> state == SQ_OSC_WAIT);
    // The hold is low in the cycle after reset (R1).
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (!hold_rst && !done));

endmodule

// File: tb/test_pwrup_sequencer.sv
module test_pwrup_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int PT = 3;
    localparam int OC = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic por_trig = 1'b0, bor_trig = 1'b0, wake_trig = 1'b0;
    logic pwrt_en = 1'b0, osc_is_rc = 1'b0, tick = 1'b0;
    logic hold_rst, done;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwrup_sequencer #(.PWR_TICKS(PT), .OSC_CYCLES(OC)) i_pwrup_sequencer (
        .clk(clk), .rst(rst), .por_trig(por_trig), .bor_trig(bor_trig),
        .wake_trig(wake_trig), .pwrt_en(pwrt_en), .osc_is_rc(osc_is_rc),
        .tick(tick), .hold_rst(hold_rst), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Strobe bits: [0] power-on, [1] brown-out, [2] wake.
    function automatic int exp_len(input logic [2:0] t, input bit pw, input bit rc, input int p);
        bit np, no;
        no = !rc;
        if (t[0])      np = pw;
        else if (t[1]) np = pw | rc;
        else           np = 1'b0;
        return (np ? p * PT : 0) + (no ? OC : 0) + 1;
    endfunction

    function automatic string tag_for(input logic [2:0] t, input bit pw, input bit rc);
        if (!t[0] && !t[1]) return "R6";
        if (!rc) return pw ? "R2" : "R3";
        return pw ? "R4" : "R5";
    endfunction

    task automatic drive_trig(input logic [2:0] t);
        por_trig  = t[0];
        bor_trig  = t[1];
        wake_trig = t[2];
    endtask

    // Strobe t1 at edge 0; optional strobe t2 at edge m (m=0: none).
    task automatic run(input logic [2:0] t1, input logic [2:0] t2, input int m,
                       input bit pw, input bit rc, input int p, input int expected,
                       input string tag);
        int e = 0;
        int len = 0;
        int done_n = 0;
        int done_at = -1;
        bit finished = 0;
        @(negedge clk);
        pwrt_en = pw; osc_is_rc = rc; tick = 1'b0;
        drive_trig(t1);
        for (int i = 1; i < 200 && !finished; i++) begin
            @(negedge clk);
            if (i > e) begin
                if (hold_rst) begin
                    len++;
                    if (done) begin done_n++; done_at = len; end
                end else if (i > m) begin
                    finished = 1;
                end
            end
            if (!finished) begin
                drive_trig(3'b000);
                if (m > 0 && i == m) begin
                    drive_trig(t2);
                    if (t2[0] || t2[1]) begin
                        e = m; len = 0; done_n = 0; done_at = -1;
                        tick = 1'b0;
                    end else begin
                        tick = ((i - e) % p) == 0;
                    end
                end else begin
                    tick = ((i - e) % p) == 0;
                end
            end
        end
        drive_trig(3'b000);
        tick = 1'b0;
        chk(len == expected, {tag, " hold length"}, len, expected);
        chk(done_n == 1 && done_at == len, {"R8 done in last hold cycle (", tag, ")"},
            done_at, len);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        // R1: reset state, and a strobe sampled together with reset
        repeat (3) @(negedge clk);
        chk(!hold_rst && !done, "R1 reset state", hold_rst, 0);
        por_trig = 1'b1;
        @(negedge clk);
        por_trig = 1'b0;
        @(negedge clk);
        chk(!hold_rst, "R1 strobe during reset ignored", hold_rst, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!hold_rst && !done, "R1 idle after reset", hold_rst, 0);

        // R2..R6 sweep over event kind, timer enable, oscillator mode and tick spacing
        for (int k = 0; k < 3; k++) begin
            for (int pw = 0; pw < 2; pw++) begin
                for (int rc = 0; rc < 2; rc++) begin
                    for (int p = 1; p <= 3; p++) begin
                        logic [2:0] t;
                        t = 3'b001 << k;
                        run(t, 3'b000, 0, pw[0], rc[0], p,
                            exp_len(t, pw[0], rc[0], p), tag_for(t, pw[0], rc[0]));
                        @(negedge clk);
                        chk(!hold_rst, "R8 idle after sequence", hold_rst, 0);
                    end
                end
            end
        end

        // R10: widely spaced ticks continue during the clock count
        run(3'b001, 3'b000, 0, 1'b1, 1'b0, 3, 3 * PT + OC + 1, "R10");

        // R7: a brown-out restarts during the tick wait, a power-on restarts during the clock count
        run(3'b001, 3'b010, 2, 1'b1, 1'b0, 1, exp_len(3'b010, 1'b1, 1'b0, 1), "R7 restart pwr");
        run(3'b010, 3'b001, PT + 3, 1'b1, 1'b0, 1, exp_len(3'b001, 1'b1, 1'b0, 1), "R7 restart osc");
        // R7: a wake during the hold changes nothing
        run(3'b001, 3'b100, 2, 1'b1, 1'b0, 1, exp_len(3'b001, 1'b1, 1'b0, 1), "R7 wake ignored pwr");
        run(3'b001, 3'b100, PT + 3, 1'b1, 1'b0, 1, exp_len(3'b001, 1'b1, 1'b0, 1), "R7 wake ignored osc");

        // R9: priority among simultaneous strobes (RC mode, timer off separates them)
        run(3'b011, 3'b000, 0, 1'b0, 1'b1, 2, 1, "R9 power-on over brown-out");
        run(3'b110, 3'b000, 0, 1'b0, 1'b1, 2, 2 * PT + 1, "R9 brown-out over wake");
        run(3'b111, 3'b000, 0, 1'b1, 1'b0, 1, PT + OC + 1, "R9 power-on over all");

        // R1: reset aborts a running sequence
        @(negedge clk);
        pwrt_en = 1'b1; osc_is_rc = 1'b0;
        por_trig = 1'b1;
        @(negedge clk);
        por_trig = 1'b0;
        @(negedge clk);
        chk(hold_rst, "R1 sequence running before reset", hold_rst, 1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(!hold_rst && !done, "R1 reset aborts sequence", hold_rst, 0);
        repeat (OC + 2) @(negedge clk);
        chk(!hold_rst, "R1 stays idle after abort", hold_rst, 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule